// File: doc/BRIEF.md
# Floating-Point Operand Screening Unit

This unit inspects a 64-bit double-precision operand on its way into an arithmetic pipeline and decides, in the same cycle, whether the instruction must trap. It also tells the status logic whether the sticky invalid-operation bit has to be set, and whether a trap should carry a software-completion qualifier. Its inputs are the operand itself, a valid strobe and a two-bit instruction-class selector. A flush-to-zero control changes the outcome only in software-completion mode.

Three policies share one operand classifier. Each operand is sorted into zero, subnormal, normal, infinity or NaN by its exponent and fraction fields. The classifier looks at bits 62:52 (exponent) and bits 51:0 (fraction), and the sign bit 63 never changes the class. A policy table chosen by the class selector then turns the class into the three result strobes. Storing the status register and delivering the trap belong to the surrounding logic.

Top module: `fp_operand_screen`

## Requirements
- R1: An operand with exponent bits 62:52 all zero and fraction bits 51:0 all zero (either sign) never raises any output, in any mode and for either flush setting.
- R2: A normal operand (exponent neither all zeros nor all ones) never raises any output.
- R3: In plain mode (mode_i = 2'b00), a subnormal operand (zero exponent, nonzero fraction) raises trap_o, with inv_set_o and swc_o low.
- R4: In plain mode, an operand with an all-ones exponent (infinity or NaN) raises both trap_o and inv_set_o, with swc_o low.
- R5: In compare mode (mode_i = 2'b01), an infinity (all-ones exponent, zero fraction) raises no output.
- R6: In compare mode, a NaN (all-ones exponent, nonzero fraction) raises trap_o and inv_set_o. A subnormal raises trap_o alone.
- R7: In software-completion mode (mode_i = 2'b10) with ftz_i low, a subnormal of either sign raises trap_o and swc_o, with inv_set_o low.
- R8: In software-completion mode, infinities and NaNs raise no output. With ftz_i high, subnormals raise no output either.
- R9: While valid_i is low, all three outputs are low whatever the other inputs are.
- R10: The unused selector value 2'b11 raises no output for any operand.
- R11: swc_o is high only together with trap_o, and inv_set_o is high only together with trap_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| valid_i | input | 1 | Operand present this cycle |
| opnd_i | input | 64 | Double-precision operand to screen |
| mode_i | input | 2 | Instruction class: 00 plain, 01 compare, 10 software completion, 11 unused |
| ftz_i | input | 1 | Flush-inputs-to-zero control, acts in software-completion mode only |
| trap_o | output | 1 | Trap request for this operand |
| swc_o | output | 1 | Trap carries the software-completion qualifier |
| inv_set_o | output | 1 | Set strobe for the sticky invalid status bit |

## Verification
The assertions are evaluated combinationally. They assume that every input holds a known 0/1 value whenever it is evaluated and that mode_i may take any of its four codes. No assumption is made about which operand classes arrive in which order. The stimulus drives each operand as a complete word on the falling clock edge and never leaves a bit undriven. The random operands are assembled from an explicit class pick, so every class, including the rare ones, appears often next to random signs, fractions, modes, flush settings and valid values.

// File: rtl/fps_pkg.sv
package fps_pkg;

    localparam int DP_EXP_W  = 11;
    localparam int DP_FRAC_W = 52;

    typedef enum logic [1:0] {
        CHK_PLAIN = 2'b00,
        CHK_CMP   = 2'b01,
        CHK_SWC   = 2'b10,
        CHK_RSVD  = 2'b11
    } chk_mode_e;

    typedef enum logic [2:0] {
        OPC_ZERO = 3'd0,
        OPC_SUBN = 3'd1,
        OPC_NORM = 3'd2,
        OPC_INF  = 3'd3,
        OPC_NAN  = 3'd4
    } opnd_class_e;

    typedef struct packed {
        logic trap;
        logic swc;
        logic inv_set;
    } screen_res_t;

endpackage

// File: rtl/fps_classify.sv
module fps_classify
    import fps_pkg::*;
#(
    parameter int EXP_W  = DP_EXP_W,
    parameter int FRAC_W = DP_FRAC_W
) (
    input  logic [EXP_W+FRAC_W:0] opnd_i,
    output opnd_class_e           cls_o
);
    localparam int EXP_LSB = FRAC_W;
    localparam int EXP_MSB = FRAC_W + EXP_W - 1;

    logic [EXP_W-1:0]  exp_fld;
    logic [FRAC_W-1:0] frac_fld;
    logic              exp_zero;
    logic              exp_ones;
    logic              frac_nz;

    always_comb begin
        exp_fld  = opnd_i[EXP_MSB:EXP_LSB];
        frac_fld = opnd_i[FRAC_W-1:0];
        exp_zero = (exp_fld == '0);
        exp_ones = &exp_fld;
        frac_nz  = |frac_fld;
    end

    always_comb begin
        if (exp_zero) begin
            cls_o = frac_nz ? OPC_SUBN : OPC_ZERO;
        end else if (exp_ones) begin
            cls_o = frac_nz ? OPC_NAN : OPC_INF;
        end else begin
            cls_o = OPC_NORM;
        end
    end

endmodule

// File: rtl/fps_policy.sv
module fps_policy
    import fps_pkg::*;
(
    input  opnd_class_e cls_i,
    input  logic [1:0]  mode_i,
    input  logic        ftz_i,
    output screen_res_t res_o
);
    chk_mode_e   mode_d;
    screen_res_t res_d;

    always_comb begin
        mode_d = chk_mode_e'(mode_i);
        res_d  = '0;
        unique case (mode_d)
            CHK_PLAIN: begin
                unique case (cls_i)
                    OPC_SUBN: res_d.trap = 1'b1;
                    OPC_INF, OPC_NAN: begin
                        res_d.trap    = 1'b1;
                        res_d.inv_set = 1'b1;
                    end
                    default: res_d = '0;
                endcase
            end
            CHK_CMP: begin
                unique case (cls_i)
                    OPC_SUBN: res_d.trap = 1'b1;
                    OPC_NAN: begin
                        res_d.trap    = 1'b1;
                        res_d.inv_set = 1'b1;
                    end
                    default: res_d = '0;
                endcase
            end
            CHK_SWC: begin
                if (cls_i == OPC_SUBN && !ftz_i) begin
                    res_d.trap = 1'b1;
                    res_d.swc  = 1'b1;
                end
            end
            default: res_d = '0;
        endcase
        res_o = res_d;
    end

endmodule

// File: rtl/fp_operand_screen.sv
module fp_operand_screen
    import fps_pkg::*;
#(
    parameter int EXP_W  = DP_EXP_W,
    parameter int FRAC_W = DP_FRAC_W
) (
    input  logic                   valid_i,
    input  logic [EXP_W+FRAC_W:0]  opnd_i,
    input  logic [1:0]             mode_i,
    input  logic                   ftz_i,
    output logic                   trap_o,
    output logic                   swc_o,
    output logic                   inv_set_o
);
    opnd_class_e cls_d;
    screen_res_t pol_d;
    screen_res_t out_d;

    fps_classify #(
        .EXP_W  (EXP_W),
        .FRAC_W (FRAC_W)
    ) u_classify (
        .opnd_i (opnd_i),
        .cls_o  (cls_d)
    );

    fps_policy u_policy (
        .cls_i  (cls_d),
        .mode_i (mode_i),
        .ftz_i  (ftz_i),
        .res_o  (pol_d)
    );

    always_comb begin
        out_d     = valid_i ? pol_d : '0;
        trap_o    = out_d.trap;
        swc_o     = out_d.swc;
        inv_set_o = out_d.inv_set;
    end

endmodule

// File: rtl/fps_checker.sv
module fps_checker #(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52
) (
    input logic                  valid_i,
    input logic [EXP_W+FRAC_W:0] opnd_i,
    input logic [1:0]            mode_i,
    input logic                  ftz_i,
    input logic                  trap_o,
    input logic                  swc_o,
    input logic                  inv_set_o
);
    logic ex_zero;
    logic ex_ones;
    logic fr_nz;

    always_comb begin
        ex_zero = (opnd_i[FRAC_W+EXP_W-1:FRAC_W] == '0);
        ex_ones = &opnd_i[FRAC_W+EXP_W-1:FRAC_W];
        fr_nz   = |opnd_i[FRAC_W-1:0];
    end

    always_comb begin
        AST_IDLE_QUIET: assert (valid_i || !(trap_o || swc_o || inv_set_o)); // R9
        AST_SWC_NEEDS_TRAP: assert (!swc_o || trap_o); // R11
        AST_INV_NEEDS_TRAP: assert (!inv_set_o || trap_o); // R11
        AST_ZERO_PASS: assert (!(ex_zero && !fr_nz) || !trap_o); // R1
        AST_NORMAL_PASS: assert (ex_zero || ex_ones || !trap_o); // R2
        AST_CMP_INF_PASS: assert (!(mode_i == 2'b01 && ex_ones && !fr_nz) || !trap_o); // R5
        AST_SWC_FTZ_PASS: assert (!(mode_i == 2'b10 && ftz_i) || !trap_o); // R8
        AST_RSVD_PASS: assert (mode_i != 2'b11 || !trap_o); // R10
        AST_SUBN_NO_INV: assert (!(ex_zero && fr_nz) || !inv_set_o); // R3
    end

endmodule

bind fp_operand_screen fps_checker #(
    .EXP_W  (EXP_W),
    .FRAC_W (FRAC_W)
) u_fps_checker (
    .valid_i   (valid_i),
    .opnd_i    (opnd_i),
    .mode_i    (mode_i),
    .ftz_i     (ftz_i),
    .trap_o    (trap_o),
    .swc_o     (swc_o),
    .inv_set_o (inv_set_o)
);

// File: tb/fp_operand_screen_test.sv
module fp_operand_screen_test;

    logic        clk = 1'b0;
    logic        valid_i = 1'b0;
    logic [63:0] opnd_i = '0;
    logic [1:0]  mode_i = '0;
    logic        ftz_i = 1'b0;
    logic        trap_o, swc_o, inv_set_o;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    fp_operand_screen uut (
        .valid_i   (valid_i),
        .opnd_i    (opnd_i),
        .mode_i    (mode_i),
        .ftz_i     (ftz_i),
        .trap_o    (trap_o),
        .swc_o     (swc_o),
        .inv_set_o (inv_set_o)
    );

    // kind: 0 zero, 1 subnormal, 2 normal, 3 infinity, 4 quiet NaN, 5 signalling NaN
    function automatic logic [63:0] make_op(int kind, bit sgn, logic [51:0] rf, logic [10:0] re);
        logic [63:0] v;
        logic [51:0] f;
        logic [10:0] e;
        f = rf;
        e = re;
        case (kind)
            0: begin e = 11'h000; f = '0; end
            1: begin e = 11'h000; if (f == '0) f = 52'h1; end
            2: begin if (e == 11'h000 || e == 11'h7ff) e = 11'h3ff; end
            3: begin e = 11'h7ff; f = '0; end
            4: begin e = 11'h7ff; f[51] = 1'b1; end
            default: begin e = 11'h7ff; f[51] = 1'b0; if (f == '0) f = 52'h2; end
        endcase
        v = {sgn, e, f};
        return v;
    endfunction

    // expected {trap, swc, inv_set} from the requirements
    function automatic logic [2:0] expect_res(logic [63:0] op, logic [1:0] m, bit ftz, bit vld);
        bit subn, inf, nan;
        subn = (op[62:52] == 11'h000) && (op[51:0] != '0);
        inf  = (op[62:52] == 11'h7ff) && (op[51:0] == '0);
        nan  = (op[62:52] == 11'h7ff) && (op[51:0] != '0);
        if (!vld) return 3'b000;
        case (m)
            2'b00: if (subn) return 3'b100; else if (inf || nan) return 3'b101;
            2'b01: if (subn) return 3'b100; else if (nan) return 3'b101;
            2'b10: if (subn && !ftz) return 3'b110;
            default: ;
        endcase
        return 3'b000;
    endfunction

    function automatic string req_tag(logic [63:0] op, logic [1:0] m, bit ftz, bit vld);
        bit zer, subn, inf, nan;
        zer  = (op[62:52] == 11'h000) && (op[51:0] == '0);
        subn = (op[62:52] == 11'h000) && (op[51:0] != '0);
        inf  = (op[62:52] == 11'h7ff) && (op[51:0] == '0);
        nan  = (op[62:52] == 11'h7ff) && (op[51:0] != '0);
        if (!vld) return "R9";
        if (m == 2'b11) return "R10";
        if (zer) return "R1";
        if (!(subn || inf || nan)) return "R2";
        case (m)
            2'b00: return subn ? "R3" : "R4";
            2'b01: return inf ? "R5" : "R6";
            default: return (subn && !ftz) ? "R7" : "R8";
        endcase
    endfunction

    task automatic apply(logic [63:0] op, logic [1:0] m, bit ftz, bit vld);
        logic [2:0] exp_r;
        logic [2:0] got;
        @(negedge clk);
        opnd_i  = op;
        mode_i  = m;
        ftz_i   = ftz;
        valid_i = vld;
        #2;
        exp_r = expect_res(op, m, ftz, vld);
        got   = {trap_o, swc_o, inv_set_o};
        n_vec++;
        if (got !== exp_r) begin
            n_fail++;
            $display("FAIL %s op=%h mode=%b ftz=%0b valid=%0b got=%b expected=%b",
                     req_tag(op, m, ftz, vld), op, m, ftz, vld, got, exp_r);
        end
        // R11: qualifier and sticky set never appear without a trap
        n_vec++;
        if ((swc_o && !trap_o) || (inv_set_o && !trap_o)) begin
            n_fail++;
            $display("FAIL R11 got=%b expected trap with qualifiers", got);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired got=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin : stim
        int seed_dummy;
        seed_dummy = $urandom(32'h5eed_0a17);
        // reset state: idle inputs give quiet outputs (R9)
        #2;
        n_vec++;
        if ({trap_o, swc_o, inv_set_o} !== 3'b000) begin
            n_fail++;
            $display("FAIL R9 idle got=%b expected=000", {trap_o, swc_o, inv_set_o});
        end
        // directed sweep: every kind, both signs, all modes, both flush settings, both valid
        for (int k = 0; k < 6; k++) begin
            for (int s = 0; s < 2; s++) begin
                for (int m = 0; m < 4; m++) begin
                    for (int f = 0; f < 2; f++) begin
                        for (int v = 0; v < 2; v++) begin
                            apply(make_op(k, s[0], 52'h8_0000_1234_5678, 11'h400),
                                  m[1:0], f[0], v[0]);
                        end
                    end
                end
            end
        end
        // corner cases: smallest and largest subnormal, largest normal, smallest normal
        apply(64'h0000_0000_0000_0001, 2'b10, 1'b0, 1'b1); // R7
        apply(64'h800F_FFFF_FFFF_FFFF, 2'b10, 1'b0, 1'b1); // R7 negative
        apply(64'h800F_FFFF_FFFF_FFFF, 2'b10, 1'b1, 1'b1); // R8 flushed
        apply(64'h7FEF_FFFF_FFFF_FFFF, 2'b00, 1'b0, 1'b1); // R2
        apply(64'h0010_0000_0000_0000, 2'b01, 1'b0, 1'b1); // R2
        apply(64'hFFF0_0000_0000_0000, 2'b01, 1'b0, 1'b1); // R5
        apply(64'hFFF0_0000_0000_0001, 2'b01, 1'b0, 1'b1); // R6
        apply(64'h7FF0_0000_0000_0000, 2'b00, 1'b1, 1'b1); // R4
        apply(64'h8000_0000_0000_0000, 2'b00, 1'b0, 1'b1); // R1
        // constrained random
        for (int i = 0; i < 2000; i++) begin
            int kind;
            kind = int'($urandom_range(0, 5));
            apply(make_op(kind, 1'($urandom), {$urandom, $urandom} >> 12, 11'($urandom)),
                  2'($urandom), 1'($urandom), ($urandom_range(0, 7) != 0));
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule